// File: doc/BRIEF.md
# Second-Level Memory Access Router

This block sits behind the first-level data store and decides, for every first-level miss, which resource serves it. The 64 KB of on-chip second-level memory is shared between a plain, software-addressable SRAM part and a part used as second-level cache. The split is chosen at run time by a small size field, and the cache part always occupies the top of the internal range. Every external page also has its own cacheability bit, held in a register bank that software writes through a simple write port.

For each miss the block returns a route code two cycles later, together with the address of the 128-byte second-level line that contains the miss. The four routes are internal SRAM, external through the second-level cache, direct external fetch, and reject. Reject means an internal address that lies inside the part currently used as cache. The block also screens DMA writes. A DMA write into the SRAM part or to external memory is accepted. A DMA write into the cache part is dropped and sets a sticky error flag, which stays set until software clears it.

Top module: `l2_route_ctl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rsp_valid`, `dma_wr_accept`, `dma_wr_drop` and `dma_err` are 0.
- R2: A miss presented with `miss_valid` at a clock edge appears on `rsp_valid` two edges later. `rsp_line` then equals the miss address with its low 7 bits cleared (128-byte line). Without a miss, `rsp_valid` stays 0.
- R3: `cache_size` decodes as follows: 0 means no cache; 1, 2 and 3 mean 16, 32 and 48 KB; 4 to 7 mean all 64 KB. The cache part covers internal offsets from 0x10000 minus that size up to 0xFFFF, and a nonzero size enables the cache.
- R4: An internal address (bits 31:16 all zero) below the cache part returns route 0 (SRAM).
- R5: An internal address inside the cache part returns route 3 (reject).
- R6: An external address (bits 31:16 not all zero) returns route 1 (through second-level cache) when the cache is enabled and the page bit selected by address bits 31:24 is 1.
- R7: An external address returns route 2 (direct external) when the cache is disabled or its page bit is 0.
- R8: `pg_we` writes `pg_cacheable` into page bit `pg_idx`. A miss sampled at the same edge still sees the old bit, and later misses see the new one.
- R9: A DMA write whose address is outside the cache part raises `dma_wr_accept` for one cycle, one edge after it is presented.
- R10: A DMA write into the cache part raises `dma_wr_drop` instead of `dma_wr_accept` one edge later, and `dma_err` is 1 in that same cycle.
- R11: `dma_err` stays 1 until an edge where `dma_err_clr` is 1. A drop at that same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_size | input | 3 | Cache part size code |
| pg_we | input | 1 | Page bit write strobe |
| pg_idx | input | 8 | Page bit index to write |
| pg_cacheable | input | 1 | Value written to the page bit |
| miss_valid | input | 1 | Miss request present |
| miss_addr | input | 32 | Miss byte address |
| rsp_valid | output | 1 | Route result valid |
| rsp_route | output | 2 | 0 SRAM, 1 cached external, 2 direct external, 3 reject |
| rsp_line | output | 32 | 128-byte aligned line address of the miss |
| dma_wr_valid | input | 1 | DMA write present |
| dma_wr_addr | input | 32 | DMA write byte address |
| dma_err_clr | input | 1 | Clears the DMA error flag |
| dma_wr_accept | output | 1 | DMA write allowed |
| dma_wr_drop | output | 1 | DMA write discarded |
| dma_err | output | 1 | Sticky DMA error flag |

## Verification
Each size code is applied with addresses placed one byte on either side of the SRAM/cache boundary, plus the first and last internal byte. This separates an off-by-one boundary from a wrong size decode, including the saturating codes 5 to 7. External misses are sent to pages whose bit is set and to pages whose bit is clear, with the cache on and off, which separates the page-bit term from the cache-enable term. A page write that coincides with a miss to the same page shows whether the read happens before the write. A long random phase then mixes misses, page writes, DMA writes and error clears, including drops and clears at the same edge.

// File: rtl/l2r_pkg.sv
package l2r_pkg;
  typedef enum logic [1:0] {
    RT_SRAM   = 2'd0,
    RT_CACHED = 2'd1,
    RT_DIRECT = 2'd2,
    RT_REJECT = 2'd3
  } route_e;
endpackage

// File: rtl/l2r_region.sv
// Decodes whether an address is internal and whether it lies in the cache part.
module l2r_region #(
  parameter int AW     = 32,
  parameter int INT_AW = 16,
  parameter int SEG_AW = 14,
  parameter int SZ_W   = 3
) (
  input  logic [AW-1:0]   addr,
  input  logic [SZ_W-1:0] size_code,
  output logic            is_int,
  output logic            in_cache
);
  localparam int NSEG = 1 << (INT_AW - SEG_AW);
  localparam int SEGW = INT_AW - SEG_AW + 1;

  logic [SEGW-1:0]   segs;
  logic [INT_AW:0]   limit;

  always_comb begin
    if (int'(size_code) >= NSEG) segs = SEGW'(NSEG);
    else                         segs = SEGW'(size_code);
    limit    = ((INT_AW+1)'(1) << INT_AW) - {segs, {SEG_AW{1'b0}}};
    is_int   = (addr[AW-1:INT_AW] == '0);
    in_cache = is_int && ({1'b0, addr[INT_AW-1:0]} >= limit);
  end
endmodule

// File: rtl/l2r_page_bank.sv
// Per-page cacheability bits; synchronous read returns the value before a same-edge write.
module l2r_page_bank #(
  parameter int PAGE_AW = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [PAGE_AW-1:0] widx,
  input  logic               wbit,
  input  logic [PAGE_AW-1:0] ridx,
  output logic               rbit
);
  localparam int NPAGES = 1 << PAGE_AW;

  logic mem [NPAGES];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wbit;
    rbit <= mem[ridx];
  end
endmodule

// File: rtl/l2r_dma_guard.sv
// Accepts or drops DMA writes and keeps the sticky error flag.
module l2r_dma_guard (
  input  logic clk,
  input  logic rst,
  input  logic wr_valid,
  input  logic hits_cache,
  input  logic err_clr,
  output logic accept,
  output logic drop,
  output logic err
);
  logic drop_d;

  assign drop_d = wr_valid && hits_cache;

  always_ff @(posedge clk) begin
    if (rst) begin
      accept <= 1'b0;
      drop   <= 1'b0;
      err    <= 1'b0;
    end else begin
      accept <= wr_valid && !hits_cache;
      drop   <= drop_d;
      err    <= drop_d || (err && !err_clr);
    end
  end
endmodule

// File: rtl/l2_route_ctl.sv
module l2_route_ctl #(
  parameter int AW      = 32,
  parameter int INT_AW  = 16,
  parameter int SEG_AW  = 14,
  parameter int SZ_W    = 3,
  parameter int PAGE_AW = 8,
  parameter int LINE_B  = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SZ_W-1:0]    cache_size,
  input  logic               pg_we,
  input  logic [PAGE_AW-1:0] pg_idx,
  input  logic               pg_cacheable,
  input  logic               miss_valid,
  input  logic [AW-1:0]      miss_addr,
  output logic               rsp_valid,
  output logic [1:0]         rsp_route,
  output logic [AW-1:0]      rsp_line,
  input  logic               dma_wr_valid,
  input  logic [AW-1:0]      dma_wr_addr,
  input  logic               dma_err_clr,
  output logic               dma_wr_accept,
  output logic               dma_wr_drop,
  output logic               dma_err
);
  import l2r_pkg::*;

  localparam int PAGE_LSB = AW - PAGE_AW;

  logic          m_int, m_inc, d_int, d_inc;
  logic          pg_bit;
  logic          s1_v, s1_int, s1_inc, s1_cen;
  logic [AW-1:0] s1_line;
  route_e        route_d;

  l2r_region #(.AW(AW), .INT_AW(INT_AW), .SEG_AW(SEG_AW), .SZ_W(SZ_W)) u_miss_rgn (
    .addr(miss_addr), .size_code(cache_size), .is_int(m_int), .in_cache(m_inc)
  );

  l2r_region #(.AW(AW), .INT_AW(INT_AW), .SEG_AW(SEG_AW), .SZ_W(SZ_W)) u_dma_rgn (
    .addr(dma_wr_addr), .size_code(cache_size), .is_int(d_int), .in_cache(d_inc)
  );

  l2r_page_bank #(.PAGE_AW(PAGE_AW)) u_bank (
    .clk(clk), .we(pg_we), .widx(pg_idx), .wbit(pg_cacheable),
    .ridx(miss_addr[AW-1:PAGE_LSB]), .rbit(pg_bit)
  );

  l2r_dma_guard u_guard (
    .clk(clk), .rst(rst), .wr_valid(dma_wr_valid), .hits_cache(d_inc),
    .err_clr(dma_err_clr), .accept(dma_wr_accept), .drop(dma_wr_drop), .err(dma_err)
  );

  // Stage 1: capture decoded region, line address and cache enable.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_int  <= 1'b0;
      s1_inc  <= 1'b0;
      s1_cen  <= 1'b0;
      s1_line <= '0;
    end else begin
      s1_v    <= miss_valid;
      s1_int  <= m_int;
      s1_inc  <= m_inc;
      s1_cen  <= (cache_size != '0);
      s1_line <= {miss_addr[AW-1:LINE_B], {LINE_B{1'b0}}};
    end
  end

  always_comb begin
    if (s1_int)                route_d = s1_inc ? RT_REJECT : RT_SRAM;
    else if (s1_cen && pg_bit) route_d = RT_CACHED;
    else                       route_d = RT_DIRECT;
  end

  // Stage 2: registered result.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_route <= 2'd0;
      rsp_line  <= '0;
    end else begin
      rsp_valid <= s1_v;
      if (s1_v) begin
        rsp_route <= route_d;
        rsp_line  <= s1_line;
      end
    end
  end
endmodule

// File: rtl/l2r_chk.sv
module l2r_chk #(
  parameter int AW     = 32,
  parameter int INT_AW = 16,
  parameter int LINE_B = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          miss_valid,
  input logic [AW-1:0] miss_addr,
  input logic          rsp_valid,
  input logic [1:0]    rsp_route,
  input logic [AW-1:0] rsp_line,
  input logic          dma_wr_valid,
  input logic          dma_err_clr,
  input logic          dma_wr_accept,
  input logic          dma_wr_drop,
  input logic          dma_err
);
  AST_RSP_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(miss_valid, 2)); // R2
  AST_LINE_ADDR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_line >> LINE_B) == ($past(miss_addr, 2) >> LINE_B)) && (rsp_line[LINE_B-1:0] == '0)); // R2
  AST_SRAM_IS_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 2'd0) |-> (rsp_line[AW-1:INT_AW] == '0)); // R4
  AST_REJECT_IS_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_route == 2'd3) |-> (rsp_line[AW-1:INT_AW] == '0)); // R5
  AST_EXT_NOT_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_route == 2'd1 || rsp_route == 2'd2)) |-> (rsp_line[AW-1:INT_AW] != '0)); // R7
  AST_ACCEPT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    dma_wr_accept |-> $past(dma_wr_valid)); // R9
  AST_NO_ACCEPT_AND_DROP: assert property (@(posedge clk) disable iff (rst)
    !(dma_wr_accept && dma_wr_drop)); // R10
  AST_DROP_FLAGS_ERR: assert property (@(posedge clk) disable iff (rst)
    dma_wr_drop |-> dma_err); // R10
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dma_err && !dma_err_clr) |=> dma_err); // R11
  AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    dma_err_clr |=> (dma_err == dma_wr_drop)); // R11
endmodule

bind l2_route_ctl l2r_chk #(.AW(AW), .INT_AW(INT_AW), .LINE_B(LINE_B)) u_chk (
  .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
  .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_line(rsp_line),
  .dma_wr_valid(dma_wr_valid), .dma_err_clr(dma_err_clr),
  .dma_wr_accept(dma_wr_accept), .dma_wr_drop(dma_wr_drop), .dma_err(dma_err)
);

// File: tb/l2_route_ctl_bench.sv
`timescale 1ns/1ps
module l2_route_ctl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cache_size = 3'd0;
  logic        pg_we = 1'b0;
  logic [7:0]  pg_idx = 8'd0;
  logic        pg_cacheable = 1'b0;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_addr = 32'd0;
  logic        rsp_valid;
  logic [1:0]  rsp_route;
  logic [31:0] rsp_line;
  logic        dma_wr_valid = 1'b0;
  logic [31:0] dma_wr_addr = 32'd0;
  logic        dma_err_clr = 1'b0;
  logic        dma_wr_accept, dma_wr_drop, dma_err;

  int n_vec = 0;
  int n_bad = 0;
  int cyc_cnt = 0;
  bit started = 0;
  bit done = 0;
  string cur_tag = "";

  always #2 clk = ~clk;

  l2_route_ctl u_l2_route_ctl (
    .clk(clk), .rst(rst), .cache_size(cache_size), .pg_we(pg_we), .pg_idx(pg_idx),
    .pg_cacheable(pg_cacheable), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_line(rsp_line),
    .dma_wr_valid(dma_wr_valid), .dma_wr_addr(dma_wr_addr), .dma_err_clr(dma_err_clr),
    .dma_wr_accept(dma_wr_accept), .dma_wr_drop(dma_wr_drop), .dma_err(dma_err)
  );

  // Reference model
  bit        pg_m [256];
  int        q_v [$];
  int        q_r [$];
  bit [31:0] q_l [$];
  bit        e_acc = 0, e_drop = 0, e_err = 0;

  function automatic bit m_in_cache(bit [31:0] a, int sz);
    int bytes;
    bytes = (sz >= 4 ? 4 : sz) * 16384;
    return (a < 32'h10000) && (a >= 32'h10000 - bytes);
  endfunction

  function automatic int m_route(bit [31:0] a, int sz, bit pb);
    if (a < 32'h10000) return m_in_cache(a, sz) ? 3 : 0;
    if (sz != 0 && pb) return 1;
    return 2;
  endfunction

  function automatic string rt_tag(int r);
    case (r)
      0: return "R4";
      1: return "R6";
      2: return "R7";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q_v.delete(); q_r.delete(); q_l.delete();
      e_acc = 0; e_drop = 0; e_err = 0;
    end else begin
      q_v.push_back(miss_valid);
      q_r.push_back(m_route(miss_addr, cache_size, pg_m[miss_addr[31:24]]));
      q_l.push_back({miss_addr[31:7], 7'd0});
      if (q_v.size() > 2) begin
        void'(q_v.pop_front()); void'(q_r.pop_front()); void'(q_l.pop_front());
      end
      if (pg_we) pg_m[pg_idx] = pg_cacheable;
      e_acc  = dma_wr_valid && !m_in_cache(dma_wr_addr, cache_size);
      e_drop = dma_wr_valid && m_in_cache(dma_wr_addr, cache_size);
      e_err  = e_drop || (e_err && !dma_err_clr);
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      n_vec++;
      if (q_v.size() == 2 && q_v[0] != 0) begin
        chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk({rt_tag(q_r[0]), cur_tag}, "rsp_route", 32'(rsp_route), 32'(q_r[0]));
        chk("R2", "rsp_line", rsp_line, q_l[0]);
      end else begin
        chk(rst ? "R1" : "R2", "rsp_valid", 32'(rsp_valid), 32'd0);
      end
      chk(rst ? "R1" : "R9", "dma_wr_accept", 32'(dma_wr_accept), 32'(e_acc));
      chk(rst ? "R1" : "R10", "dma_wr_drop", 32'(dma_wr_drop), 32'(e_drop));
      chk(rst ? "R1" : "R11", "dma_err", 32'(dma_err), 32'(e_err));
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 50000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc_cnt);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic miss(logic [31:0] a);
    miss_valid = 1'b1; miss_addr = a;
    cyc();
    miss_valid = 1'b0;
  endtask

  task automatic dma(logic [31:0] a, logic clr);
    dma_wr_valid = 1'b1; dma_wr_addr = a; dma_err_clr = clr;
    cyc();
    dma_wr_valid = 1'b0; dma_err_clr = 1'b0;
  endtask

  initial begin
    started = 1;
    // R1: reset state
    repeat (4) cyc();
    rst = 1'b0;
    cyc();
    // R8: fill all page bits, pattern: idx divisible by 3
    for (int i = 0; i < 256; i++) begin
      pg_we = 1'b1; pg_idx = 8'(i); pg_cacheable = (i % 3 == 0);
      cyc();
    end
    pg_we = 1'b0;
    cyc();

    // R3 / R7: cache disabled, whole internal range is SRAM, external goes direct
    cur_tag = "/R3";
    cache_size = 3'd0;
    miss(32'h0000_0000); miss(32'h0000_1234); miss(32'h0000_FFFF);
    miss(32'h0300_0040); miss(32'h0001_0000);
    // R3: every size code, boundary on both sides
    for (int s = 1; s < 8; s++) begin
      int b;
      cache_size = 3'(s);
      b = 32'h10000 - (s >= 4 ? 4 : s) * 16384;
      if (b > 0) miss(32'(b - 1));
      miss(32'(b));
      miss(32'h0000_0000);
      miss(32'h0000_FFFF);
      miss(32'h0300_01FF);   // page 3, bit set -> R6
      miss(32'h0400_0080);   // page 4, bit clear -> R7
      cyc();
    end

    // R8: write coincides with a miss to the same page
    cur_tag = "/R8";
    cache_size = 3'd1;
    pg_we = 1'b1; pg_idx = 8'd5; pg_cacheable = 1'b1;
    miss(32'h0500_0100);     // still old bit 0 -> direct
    pg_we = 1'b0;
    miss(32'h0500_0100);     // new bit -> cached
    pg_we = 1'b1; pg_idx = 8'd5; pg_cacheable = 1'b0;
    cyc();
    pg_we = 1'b0;
    miss(32'h0500_0100);
    cyc(); cyc();

    // R9 / R10 / R11: DMA screening with 32 KB cache
    cur_tag = "";
    cache_size = 3'd2;
    dma(32'h0000_1000, 1'b0);   // R9 accept
    dma(32'h0000_7FFF, 1'b0);   // R9 accept, last SRAM byte
    dma(32'h0000_8000, 1'b0);   // R10 drop
    cyc(); cyc();               // R11 sticky
    dma(32'h8000_0000, 1'b1);   // R11 clear with external accept
    cyc();
    dma(32'h0000_9000, 1'b0);   // R10 drop again
    dma(32'h0000_FFFC, 1'b1);   // R11 drop wins over clear
    cyc();
    dma_err_clr = 1'b1; cyc(); dma_err_clr = 1'b0;
    cache_size = 3'd0;
    dma(32'h0000_F000, 1'b0);   // R9 no cache part, accepted
    cyc(); cyc();

    // Random mix of everything
    cur_tag = "/rand";
    for (int i = 0; i < 3000; i++) begin
      bit [31:0] r;
      r = $urandom;
      cache_size   = 3'($urandom_range(0, 7));
      pg_we        = ($urandom_range(0, 3) == 0);
      pg_idx       = 8'($urandom);
      pg_cacheable = 1'($urandom);
      miss_valid   = 1'($urandom);
      miss_addr    = (r[0]) ? {16'd0, r[31:16]} : {r[31:8], 8'($urandom)};
      if (!r[0] && $urandom_range(0, 3) == 0) miss_addr = {8'($urandom_range(0, 8)), 24'($urandom)};
      dma_wr_valid = 1'($urandom);
      dma_wr_addr  = r[1] ? {16'd0, 16'($urandom)} : $urandom;
      dma_err_clr  = ($urandom_range(0, 7) == 0);
      cyc();
    end
    miss_valid = 1'b0; dma_wr_valid = 1'b0; pg_we = 1'b0; dma_err_clr = 1'b0;
    repeat (4) cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule